// File: doc/BRIEF.md
# P-224 Redundant Modular Adder/Subtractor

This unit adds or subtracts two 224-bit field elements modulo the prime p = 2^224 − 2^96 + 1. Its operands and results use a redundant range: any value in [0, 2^224) is accepted and produced, so a result may equal or exceed p. No magnitude comparison against p is made. Reduction relies on the fact that 2^224 is congruent to 2^96 − 1 modulo p. The overflow above bit 223 is folded back as a small multiple of 2^96 − 1. If that fold itself overflows, a second fold is applied.

Subtraction first forms 2p + a − b. That value can never be negative, so the same folding datapath serves both operations. Its overflow count can reach 2. The correction addend is built limb by limb directly from the overflow count, using selects and no branching. The block latches its result on the clock edge where `start` is high. It raises `done` on the following cycle and otherwise holds the last result.

Top module: `mod224_addsub`

## Requirements
- R1: While `rst_n` is low, `result` is cleared to zero and `done` is low.
- R2: `done` is high in exactly the cycle after each edge on which `start` was sampled high, and low in every other cycle.
- R3: On an edge where `start` is low, `result` keeps its previous value whatever `a`, `b` and `op_sub` do.
- R4: With `op_sub` = 0 (add), `result` is congruent to a + b modulo p.
- R5: With `op_sub` = 1 (subtract), `result` is congruent to a − b modulo p, including when b > a.
- R6: An addition whose exact sum is below 2^224 returns that sum unchanged.
- R7: When the sum or biased difference reaches 2^224, the upper count h (0 or 1 for add; 0, 1 or 2 for subtract) is removed and h·(2^96 − 1) is added to the low 224 bits.
- R8: If the first fold carries past bit 223, the low 224 bits plus 2^96 − 1 are returned. For example, (2^224 − 1) + (2^224 − 1) yields 2^97 − 4. This second fold never overflows.
- R9: Subtraction starts from 2p + a − b. For example, 0 − 1 yields p − 1, and (2^224 − 1) − 0 yields 2^224 − 1.
- R10: Subtracting equal operands returns p itself and not zero, since no comparison against p is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch a new result from the current operands |
| op_sub | input | 1 | Operation select: 0 = add, 1 = subtract |
| a | input | 224 | First operand, seven 32-bit limbs, limb 0 in bits 31:0 |
| b | input | 224 | Second operand, same layout |
| result | output | 224 | Registered redundant result in [0, 2^224) |
| done | output | 1 | One-cycle pulse after a sampled `start` |

## Verification
The bench targets several corner cases:
- Sums that overflow just once: a design that drops the fold would lose 2^224 and break the congruence.
- Sums of maximal operands that force the second fold: a single-pass design would return a value off by 2^96 − 1.
- Differences with b > a, and differences whose biased value carries twice: a design without the 2p bias, or with a one-bit overflow count, would wrap modulo 2^224 and return a non-congruent value.
- Equal operands: a design that normalised would return 0 instead of p.

Back-to-back and idle cycles show whether `done` and the held result slip by a cycle.

// File: rtl/mod224_pkg.sv
package mod224_pkg;

    // Limb geometry of one field element.
    localparam int unsigned LIMB_W     = 32;
    localparam int unsigned N_LIMBS    = 7;
    localparam int unsigned DATA_W     = LIMB_W * N_LIMBS;

    // The prime is 2^DATA_W - 2^FOLD_SHIFT + 1; the fold constant is 2^FOLD_SHIFT - 1.
    localparam int unsigned FOLD_SHIFT = 96;
    localparam int unsigned FOLD_LIMBS = FOLD_SHIFT / LIMB_W;

    // Overflow count width: subtraction can overflow by up to 2.
    localparam int unsigned OVF_W      = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OVF_W-1:0]  ovf_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Registered state of the unit.
    typedef struct packed {
        word_t result;
        logic  done;
    } out_s;

    // 2p - 2^DATA_W = 2^DATA_W - 2^(FOLD_SHIFT+1) + 2.
    // This is added after a + ~b + 1, which already carries the 2^DATA_W term.
    localparam word_t BIAS_2P = ({DATA_W{1'b1}} << (FOLD_SHIFT + 1)) + word_t'(2);

endpackage

// File: rtl/mod224_limb_add.sv
// Multi-limb ripple adder: sum = x + y + cin, with the carry chained limb by limb.
module mod224_limb_add #(
    parameter int unsigned LW = 32,
    parameter int unsigned NL = 7,
    localparam int unsigned TW = LW * NL
) (
    input  logic [TW-1:0] x,
    input  logic [TW-1:0] y,
    input  logic          cin,
    output logic [TW-1:0] sum,
    output logic          cout
);

    logic [NL:0] carry;

    assign carry[0] = cin;

    for (genvar g = 0; g < NL; g++) begin : g_limb
        logic [LW:0] limb_sum;
        assign limb_sum = {1'b0, x[g*LW +: LW]}
                        + {1'b0, y[g*LW +: LW]}
                        + {{LW{1'b0}}, carry[g]};
        assign sum[g*LW +: LW] = limb_sum[LW-1:0];
        assign carry[g+1]      = limb_sum[LW];
    end

    assign cout = carry[NL];

endmodule

// File: rtl/mod224_fold_const.sv
// Builds h * (2^(SL*LW) - 1) limb by limb from a small count h, with no multiplier.
//   limb 0          : -h (two's complement in one limb)
//   limbs 1..SL-1   : all ones when h != 0
//   limb SL         : h - 1 when h != 0
//   limbs above SL  : zero
module mod224_fold_const #(
    parameter int unsigned LW = 32,
    parameter int unsigned NL = 7,
    parameter int unsigned SL = 3,
    parameter int unsigned CW = 2,
    localparam int unsigned TW = LW * NL
) (
    input  logic [CW-1:0] count,
    output logic [TW-1:0] addend
);

    logic          nonzero;
    logic [LW-1:0] count_ext;

    assign nonzero   = |count;
    assign count_ext = LW'(count);

    for (genvar g = 0; g < NL; g++) begin : g_limb
        if (g == 0) begin : g_low
            assign addend[g*LW +: LW] = '0 - count_ext;
        end else if (g < SL) begin : g_ones
            assign addend[g*LW +: LW] = {LW{nonzero}};
        end else if (g == SL) begin : g_top
            assign addend[g*LW +: LW] = count_ext - LW'(nonzero);
        end else begin : g_zero
            assign addend[g*LW +: LW] = '0;
        end
    end

endmodule

// File: rtl/mod224_addsub.sv
// Redundant modular add/subtract for p = 2^224 - 2^96 + 1 with one output register stage.
module mod224_addsub
    import mod224_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              done
);

    // ------------------------------------------------------------------
    // Operand conditioning: subtraction uses a + ~b + 1 plus the 2p bias.
    // ------------------------------------------------------------------
    op_e   op;
    word_t b_eff;
    word_t bias;

    assign op    = op_e'(op_sub);
    assign b_eff = (op == OP_SUB) ? ~b : b;
    assign bias  = (op == OP_SUB) ? BIAS_2P : '0;

    // Stage A: a +/- b.
    word_t sum_ab;
    logic  carry_ab;

    mod224_limb_add #(.LW(LIMB_W), .NL(N_LIMBS)) u_add_ab (
        .x    (a),
        .y    (b_eff),
        .cin  (op == OP_SUB),
        .sum  (sum_ab),
        .cout (carry_ab)
    );

    // Stage B: add the bias (zero for addition).
    word_t sum_bias;
    logic  carry_bias;

    mod224_limb_add #(.LW(LIMB_W), .NL(N_LIMBS)) u_add_bias (
        .x    (sum_ab),
        .y    (bias),
        .cin  (1'b0),
        .sum  (sum_bias),
        .cout (carry_bias)
    );

    // Overflow count above bit DATA_W-1: 0..1 for add, 0..2 for subtract.
    ovf_t ovf_word;
    assign ovf_word = ovf_t'(carry_ab) + ovf_t'(carry_bias);

    // ------------------------------------------------------------------
    // First fold: low part + ovf_word * (2^96 - 1).
    // ------------------------------------------------------------------
    word_t fold1_addend;
    word_t fold1_sum;
    logic  fold1_carry;

    mod224_fold_const #(
        .LW (LIMB_W),
        .NL (N_LIMBS),
        .SL (FOLD_LIMBS),
        .CW (OVF_W)
    ) u_fold1_const (
        .count  (ovf_word),
        .addend (fold1_addend)
    );

    mod224_limb_add #(.LW(LIMB_W), .NL(N_LIMBS)) u_fold1_add (
        .x    (sum_bias),
        .y    (fold1_addend),
        .cin  (1'b0),
        .sum  (fold1_sum),
        .cout (fold1_carry)
    );

    // ------------------------------------------------------------------
    // Second fold: only non-zero when the first fold carried out.
    // ------------------------------------------------------------------
    word_t fold2_addend;
    word_t fold2_sum;
    logic  fold2_carry;

    mod224_fold_const #(
        .LW (LIMB_W),
        .NL (N_LIMBS),
        .SL (FOLD_LIMBS),
        .CW (OVF_W)
    ) u_fold2_const (
        .count  (ovf_t'(fold1_carry)),
        .addend (fold2_addend)
    );

    mod224_limb_add #(.LW(LIMB_W), .NL(N_LIMBS)) u_fold2_add (
        .x    (fold1_sum),
        .y    (fold2_addend),
        .cin  (1'b0),
        .sum  (fold2_sum),
        .cout (fold2_carry)
    );

    // ------------------------------------------------------------------
    // Two-process state: next value, then register.
    // ------------------------------------------------------------------
    out_s state_d;
    out_s state_q;

    always_comb begin
        state_d      = state_q;
        state_d.done = start;
        if (start) begin
            state_d.result = fold2_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.result;
    assign done   = state_q.done;

endmodule

// File: rtl/mod224_addsub_chk.sv
module mod224_addsub_chk
    import mod224_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_sub,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic [OVF_W-1:0]  ovf,
    input logic              fold1_cout,
    input logic              fold2_cout
);

    // R2: done follows a sampled start by exactly one cycle.
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2: no done without a preceding start.
    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R3: the result is held on idle cycles.
    p_hold_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // R4: an addition can overflow by at most one.
    p_add_ovf_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_sub) |-> (ovf <= 2'd1));

    // R9: the biased difference overflows by at most two, never three.
    p_sub_ovf_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sub) |-> (ovf != 2'd3));

    // R7: the first fold can only carry if something was folded.
    p_fold1_needs_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && fold1_cout) |-> (ovf != 2'd0));

    // R8: the second fold never overflows.
    p_no_third_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !fold2_cout);

endmodule

bind mod224_addsub mod224_addsub_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_sub     (op_sub),
    .result     (result),
    .done       (done),
    .ovf        (ovf_word),
    .fold1_cout (fold1_carry),
    .fold2_cout (fold2_carry)
);

// File: tb/tb_mod224_addsub.sv
`timescale 1ns/1ps
module tb_mod224_addsub;

    localparam int W = 224;
    localparam logic [231:0] P_WIDE = (232'd1 << 224) - (232'd1 << 96) + 232'd1;
    localparam logic [231:0] FOLDK  = (232'd1 << 96) - 232'd1;
    localparam logic [231:0] TOP    = (232'd1 << 224);
    localparam logic [W-1:0] MAXV   = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] result;
    logic         done;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    mod224_addsub dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_sub (op_sub),
        .a      (a),
        .b      (b),
        .result (result),
        .done   (done)
    );

    // Behavioural reference: biased value, then fold while it is at or above 2^224.
    function automatic logic [W-1:0] ref_value(logic [W-1:0] x, logic [W-1:0] y, logic s);
        logic [231:0] v;
        if (s) v = 2 * P_WIDE + {8'b0, x} - {8'b0, y};
        else   v = {8'b0, x} + {8'b0, y};
        while (v >= TOP) v = v - TOP + FOLDK;
        return v[W-1:0];
    endfunction

    function automatic logic [231:0] ref_mod(logic [W-1:0] x, logic [W-1:0] y, logic s);
        if (s) return (({8'b0, x} % P_WIDE) + P_WIDE - ({8'b0, y} % P_WIDE)) % P_WIDE;
        return ({8'b0, x} + {8'b0, y}) % P_WIDE;
    endfunction

    task automatic check(bit ok, string tag, logic [231:0] act, logic [231:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle model, updated on the same edge as the design.
    logic [W-1:0] exp_result = '0;
    logic         exp_done   = 1'b0;
    logic         exp_sub    = 1'b0;
    logic [W-1:0] exp_a = '0, exp_b = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_result <= '0;
            exp_done   <= 1'b0;
        end else begin
            exp_done <= start;
            if (start) begin
                exp_result <= ref_value(a, b, op_sub);
                exp_sub    <= op_sub;
                exp_a      <= a;
                exp_b      <= b;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(done == exp_done, "R2 done timing", 232'(done), 232'(exp_done));
            if (!exp_done)
                check(result == exp_result, "R3 held result", 232'(result), 232'(exp_result));
            else begin
                check(result == exp_result, exp_sub ? "R5/R7 sub value" : "R4/R7 add value",
                      232'(result), 232'(exp_result));
                check(({8'b0, result} % P_WIDE) == ref_mod(exp_a, exp_b, exp_sub),
                      exp_sub ? "R5 congruence" : "R4 congruence",
                      {8'b0, result} % P_WIDE, ref_mod(exp_a, exp_b, exp_sub));
            end
        end
    end

    // Caller is at a falling edge; returns at the falling edge where the result is visible.
    task automatic do_op(logic [W-1:0] x, logic [W-1:0] y, logic s,
                         bit use_want, logic [W-1:0] want, string tag);
        a = x; b = y; op_sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (use_want) check(result == want, tag, 232'(result), 232'(want));
    endtask

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        for (int i = 0; i < 7; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin : main
        logic [W-1:0] x;
        repeat (3) @(negedge clk);
        // R1: reset state (also with start high during reset).
        start = 1'b1; a = MAXV; b = MAXV;
        @(negedge clk);
        check(result == '0, "R1 reset result", 232'(result), 232'd0);
        check(done == 1'b0, "R1 reset done", 232'(done), 232'd0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R6: no-overflow add is exact.
        do_op(224'd1000, 224'd2345, 1'b0, 1, 224'd3345, "R6 exact sum");
        do_op(MAXV - 224'd5, 224'd5, 1'b0, 1, MAXV, "R6 sum at max");
        // R7: single fold.
        do_op(MAXV, 224'd1, 1'b0, 1, FOLDK[W-1:0], "R7 single fold");
        // R8: second fold.
        do_op(MAXV, MAXV, 1'b0, 1, (224'd1 << 97) - 224'd4, "R8 second fold");
        // R9: biased subtraction.
        do_op(224'd0, 224'd1, 1'b1, 1, P_WIDE[W-1:0] - 224'd1, "R9 b greater than a");
        do_op(MAXV, 224'd0, 1'b1, 1, MAXV, "R9 double overflow count");
        // R10: equal operands give p.
        do_op(224'd0, 224'd0, 1'b1, 1, P_WIDE[W-1:0], "R10 zero minus zero");
        x = rnd_word();
        do_op(x, x, 1'b1, 1, P_WIDE[W-1:0], "R10 x minus x");

        // R3: idle cycles with changing inputs leave the result alone.
        a = rnd_word(); b = rnd_word(); op_sub = 1'b1;
        repeat (3) @(negedge clk);
        check(result == P_WIDE[W-1:0], "R3 hold across idle", 232'(result), P_WIDE);

        // R4/R5: random and near-top operands, back-to-back and with gaps.
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra, rb;
            ra = rnd_word(); rb = rnd_word();
            if (n % 4 == 1) ra = ra | (MAXV << 100);
            if (n % 4 == 2) begin ra = ra | (MAXV << 120); rb = rb | (MAXV << 120); end
            if (n % 4 == 3) rb = rb | (MAXV << 150);
            do_op(ra, rb, 1'($urandom), 0, '0, "");
            if (n % 7 == 0) @(negedge clk);
        end

        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule